// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a 32-bit RISC core that has seven operating modes. It stores 31 general-purpose physical words plus one current status word and five saved status words, 37 registers in all. At any moment it presents sixteen logical registers, R0 to R15. The five low bits of the current status word hold the mode, and the mode decides which physical copy each logical index reaches. R13 serves as the stack pointer, R14 as the link register and R15 as the program counter, which is stored inside the file.

The core reads two operands at a time through two combinational ports and writes one result per clock. The file also has three other inputs. A link request copies the program counter into the R14 of the current mode. Two status write strobes load the current or the saved status word. An exception-entry request, in a single clock edge, stores a return address in the target mode's R14, copies the current status word into the target mode's saved status word, switches the mode and loads the program counter with that mode's fixed vector.

Every request finishes on the clock edge at which it is presented, so no port stalls and none carries a ready signal. Reads are plain combinational lookups.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register and every saved status word reads zero, and the current status word reads 0x0000_0013 (mode svc, bit 5 clear).
- R2: Mode codes are usr=10000, fiq=10001, irq=10010, svc=10011, abt=10111, und=11011 and sys=11111 in status bits [4:0]. In fiq, R8 to R14 are private copies. irq, svc, abt and und each have private R13 and R14. usr and sys share one set. R0 to R7 and R15 are shared by all modes.
- R3: A status mode code outside the seven listed selects the same registers as usr and has no saved status word.
- R4: A write to R0 to R15 through the write port lands on the rising edge and is visible on the next cycle. A read of the same register in the write cycle returns the old value.
- R5: Reads of R15 force bits [1:0] to zero while status bit 5 is 0, and force only bit 0 to zero while status bit 5 is 1.
- R6: A link request writes the value R15 reads at that moment into R14 of the current mode. If the write port targets R14 in the same cycle, the link value wins.
- R7: An exception entry for target code fiq, irq, svc, abt or und, on one edge: sets R14 of the target mode to the return address, sets the target's saved status word to the current status word, sets status [4:0] to the target code, clears status bit 5, and loads R15 with the vector und=0x04, svc=0x08, abt=0x10, irq=0x18 or fiq=0x1C.
- R8: During an accepted exception entry, the write port, the link request and both status write strobes of that cycle have no effect.
- R9: An exception-entry request with any other target code is ignored entirely, and the other requests of that cycle act normally.
- R10: The saved status output shows the saved word of the current mode and reads zero in usr, sys or an unlisted mode. The saved-status write strobe loads that word, and it has no effect in usr, sys or an unlisted mode.
- R11: The current-status write strobe loads the whole status word on the edge. Register writes and link requests in the same cycle still use the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write port strobe |
| wr_idx | input | 4 | Logical index written |
| wr_data | input | 32 | Data written |
| link_en | input | 1 | Copy R15 into R14 of the current mode |
| psr_wdata | input | 32 | Data for both status write strobes |
| cpsr_wr_en | input | 1 | Load the current status word |
| spsr_wr_en | input | 1 | Load the saved status word of the current mode |
| exc_en | input | 1 | Exception-entry request |
| exc_mode | input | 5 | Target mode code of the exception |
| exc_ret_addr | input | 32 | Return address placed in the target R14 |
| cpsr_out | output | 32 | Current status word |
| spsr_out | output | 32 | Saved status word of the current mode |

## Verification
The read ports and the saved-status output are combinational on the stored state, so their values are due in the same cycle that the index or the mode is presented. Every write, link, status load and exception entry is due one cycle later, after the next rising edge. The bench changes inputs on the falling edge and compares all four outputs against its reference model shortly after that. It then applies the edge's effects to the model, which is exactly one cycle of delay and matches the single register stage on every path. A check made in a write cycle therefore sees the old value, which is the read-old behaviour required here.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  localparam int LW       = 4;   // logical index width
  localparam int NLOG     = 16;  // visible registers
  localparam int NBANK    = 6;   // usr/sys share bank 0
  localparam int NSAVED   = NBANK - 1;
  localparam int NPHYS    = NLOG + 7 + 2 * (NSAVED - 1);
  localparam int PW       = $clog2(NPHYS);
  localparam int FIQ_LO   = NLOG;          // fiq R8 sits here
  localparam int PC_IDX   = NLOG - 1;
  localparam int LR_IDX   = NLOG - 2;
  localparam int SP_IDX   = NLOG - 3;
  localparam int FIQ_FROM = 8;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // R3: any unlisted code falls back to the shared usr/sys set
  function automatic bank_e bank_of(input logic [4:0] code);
    case (code)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic is_exc_mode(input logic [4:0] code);
    return bank_of(code) != BK_USR;
  endfunction

  // Physical slot holding R13 of a bank; R14 follows it.
  function automatic logic [PW-1:0] sp_slot(input bank_e b);
    case (b)
      BK_FIQ:  return PW'(FIQ_LO + (SP_IDX - FIQ_FROM));
      BK_IRQ:  return PW'(FIQ_LO + 7);
      BK_SVC:  return PW'(FIQ_LO + 9);
      BK_ABT:  return PW'(FIQ_LO + 11);
      BK_UND:  return PW'(FIQ_LO + 13);
      default: return PW'(SP_IDX);
    endcase
  endfunction

  // R7: fixed entry addresses per target mode
  function automatic logic [31:0] vector_of(input bank_e b);
    case (b)
      BK_UND:  return 32'h0000_0004;
      BK_SVC:  return 32'h0000_0008;
      BK_ABT:  return 32'h0000_0010;
      BK_IRQ:  return 32'h0000_0018;
      BK_FIQ:  return 32'h0000_001C;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/bregs_map.sv
// Logical index plus mode code to physical slot (R2, R3).
module bregs_map
  import bregs_pkg::*;
(
  input  logic [4:0]    mode,
  input  logic [LW-1:0] idx,
  output logic [PW-1:0] phys
);
  bank_e bank;

  always_comb begin
    bank = bank_of(mode);
    phys = PW'(idx);
    if (idx == LW'(SP_IDX) || idx == LW'(LR_IDX)) begin
      phys = sp_slot(bank) + PW'(idx - LW'(SP_IDX));
    end else if (bank == BK_FIQ && idx >= LW'(FIQ_FROM) && idx < LW'(SP_IDX)) begin
      phys = PW'(FIQ_LO) + PW'(idx - LW'(FIQ_FROM));
    end
  end
endmodule

// File: rtl/bregs_gpr.sv
// Physical storage: NRD combinational reads, two write ports, port 1 wins.
module bregs_gpr #(
  parameter int DW    = 32,
  parameter int NPHYS = 31,
  parameter int NRD   = 3,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] rd_phys [NRD],
  output logic [DW-1:0] rd_data [NRD],
  input  logic          w0_en,
  input  logic [PW-1:0] w0_phys,
  input  logic [DW-1:0] w0_data,
  input  logic          w1_en,
  input  logic [PW-1:0] w1_phys,
  input  logic [DW-1:0] w1_data
);
  logic [DW-1:0] mem [NPHYS];

  for (genvar i = 0; i < NPHYS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (w1_en && w1_phys == PW'(i)) begin
        mem[i] <= w1_data;
      end else if (w0_en && w0_phys == PW'(i)) begin
        mem[i] <= w0_data;
      end
    end
  end

  // R4: reads see the stored word, so a same-cycle write is not yet visible
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem[rd_phys[r]];
  end
endmodule

// File: rtl/bregs_psr.sv
// Current status word and the per-mode saved status words (R7, R10, R11).
module bregs_psr
  import bregs_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [DW-1:0] RESET_CPSR = DW'(32'h13)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpsr_we,
  input  logic          spsr_we,
  input  logic [DW-1:0] wdata,
  input  logic          exc_take,
  input  logic [4:0]    exc_mode,
  output logic [DW-1:0] cpsr,
  output logic [DW-1:0] spsr_cur
);
  logic [DW-1:0] saved [NBANK];
  logic [DW-1:0] cpsr_entry;
  bank_e         cur_bank;
  bank_e         tgt_bank;

  assign cur_bank = bank_of(cpsr[4:0]);
  assign tgt_bank = bank_of(exc_mode);

  always_comb begin
    cpsr_entry      = cpsr;
    cpsr_entry[5]   = 1'b0;
    cpsr_entry[4:0] = exc_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr <= RESET_CPSR;
    end else if (exc_take) begin
      cpsr <= cpsr_entry;
    end else if (cpsr_we) begin
      cpsr <= wdata;
    end
  end

  assign saved[0] = '0;

  for (genvar b = 1; b < NBANK; b++) begin : g_saved
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        saved[b] <= '0;
      end else if (exc_take && tgt_bank == bank_e'(b)) begin
        saved[b] <= cpsr;
      end else if (spsr_we && cur_bank == bank_e'(b)) begin
        saved[b] <= wdata;
      end
    end
  end

  assign spsr_cur = saved[cur_bank];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] RESET_CPSR = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          link_en,
  input  logic [DW-1:0] psr_wdata,
  input  logic          cpsr_wr_en,
  input  logic          spsr_wr_en,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_ret_addr,
  output logic [DW-1:0] cpsr_out,
  output logic [DW-1:0] spsr_out
);
  localparam int NMAP = 5;   // rd A, rd B, write, link R14, exception R14
  localparam int NRD  = 3;   // rd A, rd B, PC

  logic [4:0]    map_mode [NMAP];
  logic [LW-1:0] map_idx  [NMAP];
  logic [PW-1:0] map_phys [NMAP];
  logic [PW-1:0] rd_phys  [NRD];
  logic [DW-1:0] rd_raw   [NRD];

  logic [DW-1:0] cpsr;
  logic          thumb;
  logic          exc_take;
  logic [DW-1:0] pc_view;

  logic          w0_en, w1_en;
  logic [PW-1:0] w0_phys, w1_phys;
  logic [DW-1:0] w0_data, w1_data;

  // R5: alignment mask applied on the way out of R15
  function automatic logic [DW-1:0] pc_mask(input logic [DW-1:0] v, input logic t);
    logic [DW-1:0] m;
    m    = v;
    m[0] = 1'b0;
    if (!t) m[1] = 1'b0;
    return m;
  endfunction

  assign thumb    = cpsr[5];
  assign exc_take = exc_en && is_exc_mode(exc_mode);   // R9

  assign map_mode[0] = cpsr[4:0];  assign map_idx[0] = rd_a_idx;
  assign map_mode[1] = cpsr[4:0];  assign map_idx[1] = rd_b_idx;
  assign map_mode[2] = cpsr[4:0];  assign map_idx[2] = wr_idx;
  assign map_mode[3] = cpsr[4:0];  assign map_idx[3] = LW'(LR_IDX);
  assign map_mode[4] = exc_mode;   assign map_idx[4] = LW'(LR_IDX);

  for (genvar k = 0; k < NMAP; k++) begin : g_map
    bregs_map u_map (
      .mode (map_mode[k]),
      .idx  (map_idx[k]),
      .phys (map_phys[k])
    );
  end

  assign rd_phys[0] = map_phys[0];
  assign rd_phys[1] = map_phys[1];
  assign rd_phys[2] = PW'(PC_IDX);

  bregs_gpr #(.DW(DW), .NPHYS(NPHYS), .NRD(NRD)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_phys (rd_phys),
    .rd_data (rd_raw),
    .w0_en   (w0_en),
    .w0_phys (w0_phys),
    .w0_data (w0_data),
    .w1_en   (w1_en),
    .w1_phys (w1_phys),
    .w1_data (w1_data)
  );

  assign pc_view = pc_mask(rd_raw[2], thumb);

  // R7/R8: exception entry takes both write ports; otherwise the write
  // port uses port 0 and the link request port 1, so link wins on R14 (R6)
  always_comb begin
    if (exc_take) begin
      w0_en   = 1'b1;
      w0_phys = PW'(PC_IDX);
      w0_data = DW'(vector_of(bank_of(exc_mode)));
      w1_en   = 1'b1;
      w1_phys = map_phys[4];
      w1_data = exc_ret_addr;
    end else begin
      w0_en   = wr_en;
      w0_phys = map_phys[2];
      w0_data = wr_data;
      w1_en   = link_en;
      w1_phys = map_phys[3];
      w1_data = pc_view;
    end
  end

  assign rd_a_data = (rd_a_idx == LW'(PC_IDX)) ? pc_mask(rd_raw[0], thumb) : rd_raw[0];
  assign rd_b_data = (rd_b_idx == LW'(PC_IDX)) ? pc_mask(rd_raw[1], thumb) : rd_raw[1];

  bregs_psr #(.DW(DW), .RESET_CPSR(DW'(RESET_CPSR))) u_psr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpsr_we  (cpsr_wr_en && !exc_take),
    .spsr_we  (spsr_wr_en && !exc_take),
    .wdata    (psr_wdata),
    .exc_take (exc_take),
    .exc_mode (exc_mode),
    .cpsr     (cpsr),
    .spsr_cur (spsr_out)
  );

  assign cpsr_out = cpsr;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import bregs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic        link_en,
  input logic        cpsr_wr_en,
  input logic        spsr_wr_en,
  input logic        exc_en,
  input logic [4:0]  exc_mode,
  input logic [31:0] cpsr_out,
  input logic [31:0] spsr_out
);
  logic quiet;
  assign quiet = !wr_en && !link_en && !cpsr_wr_en && !spsr_wr_en && !exc_en;

  assert_exc_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en && is_exc_mode(exc_mode) |=> cpsr_out[4:0] == $past(exc_mode) && !cpsr_out[5]);

  assert_exc_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en && is_exc_mode(exc_mode) |=> spsr_out == $past(cpsr_out));

  assert_exc_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en && is_exc_mode(exc_mode) |=>
      (rd_a_idx != 4'd15 || rd_a_data == vector_of(bank_of($past(exc_mode)))));

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en && is_exc_mode(exc_mode) && cpsr_wr_en |=> cpsr_out[4:0] == $past(exc_mode));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en && !is_exc_mode(exc_mode) && !cpsr_wr_en |=> $stable(cpsr_out));

  assert_pc_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'd15 && !cpsr_out[5] |-> rd_a_data[1:0] == 2'b00);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(rd_a_idx) -> $stable(rd_a_data)));

  assert_no_saved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_exc_mode(cpsr_out[4:0]) |-> spsr_out == 32'h0);
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .link_en    (link_en),
  .cpsr_wr_en (cpsr_wr_en),
  .spsr_wr_en (spsr_wr_en),
  .exc_en     (exc_en),
  .exc_mode   (exc_mode),
  .cpsr_out   (cpsr_out),
  .spsr_out   (spsr_out)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wdata = '0, exc_ret_addr = '0;
  logic        wr_en = 0, link_en = 0, cpsr_wr_en = 0, spsr_wr_en = 0, exc_en = 0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] cpsr_out, spsr_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .link_en(link_en), .psr_wdata(psr_wdata),
    .cpsr_wr_en(cpsr_wr_en), .spsr_wr_en(spsr_wr_en),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
    .cpsr_out(cpsr_out), .spsr_out(spsr_out)
  );

  // Reference model: one 16-entry view per mode group, kept consistent by
  // propagating writes to every group that shares the register.
  logic [31:0] m_view [6][16];
  logic [31:0] m_saved [6];
  logic [31:0] m_cpsr;
  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  localparam logic [4:0] C_USR = 5'b10000, C_FIQ = 5'b10001, C_IRQ = 5'b10010,
    C_SVC = 5'b10011, C_ABT = 5'b10111, C_UND = 5'b11011, C_SYS = 5'b11111;

  function automatic int group_of(input logic [4:0] c);
    case (c)
      C_FIQ: return 1;  C_IRQ: return 2;  C_SVC: return 3;
      C_ABT: return 4;  C_UND: return 5;  default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] entry_addr(input int g);
    case (g)
      1: return 32'h1C;  2: return 32'h18;  3: return 32'h08;
      4: return 32'h10;  5: return 32'h04;  default: return 32'h0;
    endcase
  endfunction

  task automatic put(input int g, input int k, input logic [31:0] d);
    if (k < 8 || k == 15) begin
      for (int t = 0; t < 6; t++) m_view[t][k] = d;
    end else if (k < 13) begin
      if (g == 1) m_view[1][k] = d;
      else for (int t = 0; t < 6; t++) if (t != 1) m_view[t][k] = d;
    end else begin
      m_view[g][k] = d;
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] k);
    logic [31:0] v;
    v = m_view[group_of(m_cpsr[4:0])][k];
    if (k == 4'd15) begin
      v[0] = 1'b0;
      if (!m_cpsr[5]) v[1] = 1'b0;
    end
    return v;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Inputs are set after a falling edge; compare, then take the rising edge.
  task automatic step();
    int g, t;
    logic [31:0] pcv;
    #1;
    chk("rd_a", rd_a_data, exp_rd(rd_a_idx));
    chk("rd_b", rd_b_data, exp_rd(rd_b_idx));
    chk("cpsr", cpsr_out, m_cpsr);
    g = group_of(m_cpsr[4:0]);
    chk("spsr", spsr_out, (g == 0) ? 32'h0 : m_saved[g]);
    @(posedge clk);
    pcv = exp_rd(4'd15);
    t = group_of(exc_mode);
    if (exc_en && t != 0) begin
      m_view[t][14] = exc_ret_addr;
      m_saved[t]    = m_cpsr;
      put(g, 15, entry_addr(t));
      m_cpsr[5]     = 1'b0;
      m_cpsr[4:0]   = exc_mode;
    end else begin
      if (wr_en) put(g, int'(wr_idx), wr_data);
      if (link_en) put(g, 14, pcv);
      if (spsr_wr_en && g != 0) m_saved[g] = psr_wdata;
      if (cpsr_wr_en) m_cpsr = psr_wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; link_en = 0; cpsr_wr_en = 0; spsr_wr_en = 0; exc_en = 0;
  endtask

  task automatic set_mode(input logic [4:0] c, input logic t);
    idle();
    psr_wdata = {26'h0, t, c};
    cpsr_wr_en = 1;
    step();
    idle();
  endtask

  task automatic wr(input int k, input logic [31:0] d);
    idle();
    wr_en = 1; wr_idx = 4'(k); wr_data = d;
    step();
    idle();
  endtask

  task automatic sweep();
    idle();
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      step();
    end
  endtask

  initial begin
    for (int g = 0; g < 6; g++) begin
      m_saved[g] = '0;
      for (int k = 0; k < 16; k++) m_view[g][k] = '0;
    end
    m_cpsr = 32'h13;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    tag = "R1";  // reset state, svc mode
    sweep();

    tag = "R2";  // fill usr view, then private copies per mode
    set_mode(C_USR, 0);
    for (int i = 0; i < 16; i++) wr(i, 32'hA000_0000 + i * 4);
    for (int g = 0; g < 6; g++) begin
      logic [4:0] c;
      case (g) 0: c = C_SYS; 1: c = C_FIQ; 2: c = C_IRQ; 3: c = C_SVC; 4: c = C_ABT; default: c = C_UND; endcase
      set_mode(c, 0);
      for (int i = 8; i < 15; i++) wr(i, 32'hB000_0000 + g * 256 + i);
    end
    for (int g = 0; g < 6; g++) begin
      logic [4:0] c;
      case (g) 0: c = C_USR; 1: c = C_FIQ; 2: c = C_IRQ; 3: c = C_SVC; 4: c = C_ABT; default: c = C_UND; endcase
      set_mode(c, 0);
      sweep();
    end

    tag = "R3";  // unlisted code behaves as usr
    set_mode(5'b00101, 0);
    sweep();
    wr(13, 32'h3333_0013);
    set_mode(C_USR, 0);
    sweep();

    tag = "R4";  // same-cycle read returns old, next cycle new
    idle();
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'h4444_0004;
    step();
    idle();
    step();

    tag = "R5";  // PC alignment on read
    wr(15, 32'h0000_1003);
    rd_a_idx = 4'd15; rd_b_idx = 4'd15;
    step();
    set_mode(C_USR, 1);
    rd_a_idx = 4'd15;
    step();
    set_mode(C_USR, 0);

    tag = "R6";  // link with a branch write, and link beats a write to R14
    set_mode(C_IRQ, 0);
    idle();
    link_en = 1; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0000_2000;
    step();
    idle();
    link_en = 1; wr_en = 1; wr_idx = 4'd14; wr_data = 32'hDEAD_0014;
    step();
    idle();
    rd_a_idx = 4'd14; rd_b_idx = 4'd15;
    step();

    tag = "R7";  // each exception entry from usr
    for (int g = 1; g < 6; g++) begin
      logic [4:0] c;
      case (g) 1: c = C_FIQ; 2: c = C_IRQ; 3: c = C_SVC; 4: c = C_ABT; default: c = C_UND; endcase
      set_mode(C_USR, 0);
      psr_wdata = 32'hF000_0010; cpsr_wr_en = 1;
      step();
      idle();
      exc_en = 1; exc_mode = c; exc_ret_addr = 32'h7700_0000 + g;
      rd_a_idx = 4'd14; rd_b_idx = 4'd15;
      step();
      idle();
      step();
    end

    tag = "R8";  // exception entry masks other requests
    set_mode(C_USR, 1);
    idle();
    exc_en = 1; exc_mode = C_SVC; exc_ret_addr = 32'h8800_0008;
    wr_en = 1; wr_idx = 4'd2; wr_data = 32'h8888_0002;
    link_en = 1; cpsr_wr_en = 1; spsr_wr_en = 1; psr_wdata = 32'h0000_001F;
    rd_a_idx = 4'd2; rd_b_idx = 4'd14;
    step();
    idle();
    step();
    sweep();

    tag = "R9";  // entry with a non-exception target is ignored
    idle();
    exc_en = 1; exc_mode = C_SYS; exc_ret_addr = 32'h9999_9999;
    wr_en = 1; wr_idx = 4'd5; wr_data = 32'h9900_0005;
    rd_a_idx = 4'd5; rd_b_idx = 4'd15;
    step();
    idle();
    step();
    sweep();

    tag = "R10";  // saved status write in svc and in usr
    set_mode(C_SVC, 0);
    idle();
    spsr_wr_en = 1; psr_wdata = 32'h1234_0010;
    step();
    idle();
    step();
    set_mode(C_USR, 0);
    idle();
    spsr_wr_en = 1; psr_wdata = 32'h5555_5555;
    step();
    idle();
    step();
    set_mode(C_SVC, 0);
    step();

    tag = "R11";  // status load, register write uses old mode
    idle();
    cpsr_wr_en = 1; psr_wdata = {27'h0, C_FIQ};
    wr_en = 1; wr_idx = 4'd13; wr_data = 32'h1100_000D;
    step();
    idle();
    set_mode(C_SVC, 0);
    rd_a_idx = 4'd13;
    step();

    tag = "R2 R4 R6 R7 R10 R11";  // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [4:0] c;
      idle();
      case ($urandom % 9)
        0: c = C_USR; 1: c = C_FIQ; 2: c = C_IRQ; 3: c = C_SVC; 4: c = C_ABT;
        5: c = C_UND; 6: c = C_SYS; 7: c = 5'b01010; default: c = 5'b11000;
      endcase
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
      link_en = ($urandom % 6) == 0;
      cpsr_wr_en = ($urandom % 8) == 0;
      spsr_wr_en = ($urandom % 6) == 0;
      psr_wdata = {$urandom % 8, 21'h0, 1'b0, 1'b0, ($urandom % 5) == 0, c};
      exc_en = ($urandom % 10) == 0; exc_mode = c; exc_ret_addr = $urandom;
      step();
    end
    idle();
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s: actual=timeout expected=completion", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule